// File: doc/BRIEF.md
# Multi-Way Address Interleave Decoder

This block decodes one host physical address against one interleave configuration. It reports which target owns the address and what that address becomes inside the target once the interleave bits are removed. A host-side router uses the target index to steer a request. A memory device uses the local address to turn an incoming host address into an offset in its own storage.

Power-of-two interleaves (1, 2, 4, 8 and 16 ways) pick the target from contiguous address bits just above the granule offset. The 3, 6 and 12-way interleaves need a remainder by three and a quotient by three. A bit-serial unit with a fixed latency computes both, with no general divider. The address must first fall inside a programmed window given by a base and a size. Requests enter and results leave through a valid/ready handshake, and one request is in flight at a time.

Top module: `ilv_addr_decode`

## Requirements
- R1: `cfg_ways` selects the interleave count. Codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 ways. Codes 8, 9 and 10 mean 3, 6 and 12 ways. Every other code is an error.
- R2: `cfg_gran` code g selects a granule of 2^(8+g) bytes for g from 0 to 6 (256 B to 16 KB). Code 7 is an error.
- R3: An address is inside the window when `cfg_base <= in_hpa < cfg_base + cfg_size`. The window offset is `in_hpa - cfg_base`. An address outside the window is an error.
- R4: The granule number is the offset shifted right by 8+g. The target index is the granule number modulo N, where N is the way count. For power-of-two N this is the low bits of the granule number.
- R5: In 6-way mode with 512 B granules, consecutive chunks go to targets 0, 1, 2, 3, 4, 5 and then back to 0.
- R6: The local address is (granule number / N) shifted left by 8+g, with the offset bits below the granule copied unchanged into the low bits.
- R7: On any error `out_err` is 1, and `out_tgt` and `out_dpa` are 0.
- R8: A request is accepted when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` is 0 from that edge until the result has been taken. `out_valid` rises exactly ADDR_W-8 clock cycles after the accepting edge, for every mode.
- R9: While `out_valid` is 1 and `out_ready` is 0, the result holds steady.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.
- R11: In 12-way mode with 256 B granules, each target owns exactly one of every 12 consecutive chunks, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ways | input | 4 | Way count code |
| cfg_gran | input | 3 | Granule size code |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | ADDR_W | Window size in bytes |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Decoder can accept a request |
| in_hpa | input | ADDR_W | Host physical address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tgt | output | 4 | Target index |
| out_dpa | output | ADDR_W | Local device address |
| out_err | output | 1 | Bad configuration or address outside window |

## Verification
The bench walks runs of consecutive chunks in the 3, 6 and 12-way modes. A decoder that combined the remainder and quotient bits in the wrong order would send them to targets out of sequence. It also sends random addresses at every granule size and checks the local address. An off-by-one in the iterative division, or a dropped low offset bit, would show up there. Addresses at the window base, at the last byte of the window and one byte past it, together with an unused ways code and an invalid granule code, catch an error check with the wrong bounds. Random backpressure exposes a result that changes while it waits, and a latency count on every request catches a mode-dependent or shifted completion cycle.

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode #(
  parameter int ADDR_W   = 40,
  parameter int GRAN_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_ways,
  input  logic [2:0]        cfg_gran,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_hpa,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_tgt,
  output logic [ADDR_W-1:0] out_dpa,
  output logic              out_err
);
  localparam int GW  = ADDR_W - GRAN_MIN;
  localparam int CW  = $clog2(GW);
  localparam int SHW = $clog2(ADDR_W);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;
  st_t st_q;

  logic [2:0]        k_d;
  logic              tri_d, ok_d;
  always_comb begin
    k_d = 3'd0; tri_d = 1'b0; ok_d = 1'b1;
    case (cfg_ways)
      4'd0: k_d = 3'd0;
      4'd1: k_d = 3'd1;
      4'd2: k_d = 3'd2;
      4'd3: k_d = 3'd3;
      4'd4: k_d = 3'd4;
      4'd8: tri_d = 1'b1;
      4'd9: begin tri_d = 1'b1; k_d = 3'd1; end
      4'd10: begin tri_d = 1'b1; k_d = 3'd2; end
      default: ok_d = 1'b0;
    endcase
  end

  logic [ADDR_W-1:0] off_d, low_d;
  logic [SHW-1:0]    sh_d;
  logic              err_d;
  logic [GW-1:0]     g_d;
  assign off_d = in_hpa - cfg_base;
  assign sh_d  = SHW'(GRAN_MIN) + SHW'(cfg_gran);
  assign err_d = !ok_d || (cfg_gran == 3'd7) || (in_hpa < cfg_base) || (off_d >= cfg_size);
  assign g_d   = GW'(off_d >> sh_d);
  assign low_d = off_d & ~({ADDR_W{1'b1}} << sh_d);

  logic [GW-1:0]     g_q, q_q;
  logic [1:0]        r_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] low_q;
  logic [SHW-1:0]    sh_q;
  logic [2:0]        k_q;
  logic              tri_q, err_q;

  logic [2:0] t_w;
  logic       ge3_w;
  logic [2:0] sub_w;
  assign t_w   = {r_q, g_q[cnt_q]};
  assign ge3_w = t_w >= 3'd3;
  assign sub_w = t_w - 3'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; g_q <= '0; q_q <= '0; r_q <= '0; cnt_q <= '0;
      low_q <= '0; sh_q <= '0; k_q <= '0; tri_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (in_valid) begin
          g_q <= g_d; low_q <= low_d; sh_q <= sh_d; k_q <= k_d;
          tri_q <= tri_d; err_q <= err_d;
          q_q <= '0; r_q <= '0; cnt_q <= CW'(GW - 1);
          st_q <= S_BUSY;
        end
        S_BUSY: begin
          q_q <= {q_q[GW-2:0], ge3_w};
          r_q <= ge3_w ? sub_w[1:0] : t_w[1:0];
          if (cnt_q == '0) st_q <= S_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: if (out_ready) st_q <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0] msk_w, lg_w;
  logic [5:0]    tw_w;
  assign msk_w = ~({GW{1'b1}} << k_q);
  assign lg_w  = tri_q ? (q_q >> k_q) : (g_q >> k_q);
  assign tw_w  = tri_q ? 6'(r_q) + 6'd3 * 6'(q_q & msk_w) : 6'(g_q & msk_w);

  assign in_ready  = (st_q == S_IDLE);
  assign out_valid = (st_q == S_DONE);
  assign out_err   = err_q;
  assign out_tgt   = err_q ? 4'd0 : tw_w[3:0];
  assign out_dpa   = err_q ? '0 : ((ADDR_W'(lg_w) << sh_q) | low_q);

  logic [4:0] nways_w;
  assign nways_w = tri_q ? 5'(3 << k_q) : 5'(1 << k_q);

  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);
  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tgt) && $stable(out_dpa) && $stable(out_err));
  assert_target_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> 5'(out_tgt) < nways_w);
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_q != 2'd3);
endmodule

// File: tb/test_ilv_addr_decode.sv
module test_ilv_addr_decode;
  localparam int AW  = 40;
  localparam int LAT = AW - 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_ways = '0;
  logic [2:0] cfg_gran = '0;
  logic [AW-1:0] cfg_base = '0, cfg_size = '0, in_hpa = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_err;
  logic [3:0] out_tgt;
  logic [AW-1:0] out_dpa;

  always #4 clk = ~clk;

  ilv_addr_decode #(.ADDR_W(AW)) i_ilv_addr_decode (
    .clk(clk), .rst_n(rst_n), .cfg_ways(cfg_ways), .cfg_gran(cfg_gran),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .in_valid(in_valid), .in_ready(in_ready),
    .in_hpa(in_hpa), .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt),
    .out_dpa(out_dpa), .out_err(out_err));

  int checks = 0, errors = 0, cyc = 0;
  bit bp_mode = 0, seen = 0, held = 0, done = 0;
  logic [3:0] h_tgt; logic [AW-1:0] h_dpa; logic h_err;
  int q_tgt[$]; longint unsigned q_dpa[$]; bit q_err[$]; int q_acc[$]; string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nways(int code);
    case (code)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 16;
      8: return 3; 9: return 6; 10: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic send(longint unsigned hpa, int ways, int gran, string tag);
    longint unsigned off, g, dpa;
    int n, sh;
    bit e;
    n = nways(ways); sh = 8 + gran;
    off = hpa - longint'(cfg_base);
    e = (n == 0) || (gran == 7) || (hpa < longint'(cfg_base)) || (off >= longint'(cfg_size));
    if (e) begin
      q_tgt.push_back(0); q_dpa.push_back(0);
    end else begin
      g = off >> sh;
      dpa = ((g / longint'(n)) << sh) | (off & ((64'd1 << sh) - 1));
      q_tgt.push_back(int'(g % longint'(n))); q_dpa.push_back(dpa);
    end
    q_err.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    cfg_ways = 4'(ways); cfg_gran = 3'(gran); in_hpa = AW'(hpa); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_acc.push_back(cyc);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (held) chk(out_valid && out_tgt == h_tgt && out_dpa == h_dpa && out_err == h_err,
                  "R9", "held result", {out_valid, out_tgt}, {1'b1, h_tgt});
    held = 0;
    if (out_valid && !seen) begin
      seen = 1;
      if (q_acc.size() > 0) chk(cyc - q_acc[0] == LAT, "R8", "latency", cyc - q_acc[0], LAT);
    end
    out_ready = bp_mode ? ($urandom % 3 == 0) : 1'b1;
    if (out_valid && !out_ready) begin
      held = 1; h_tgt = out_tgt; h_dpa = out_dpa; h_err = out_err;
    end
    if (out_valid && out_ready && q_tgt.size() > 0) begin
      string tg;
      tg = q_tag.pop_front();
      chk(out_err == q_err[0], tg, "err", out_err, q_err[0]);
      chk(out_tgt == 4'(q_tgt[0]), tg, "tgt", out_tgt, q_tgt[0]);
      chk(out_dpa == AW'(q_dpa[0]), tg, "dpa", out_dpa, q_dpa[0]);
      void'(q_err.pop_front()); void'(q_tgt.pop_front()); void'(q_dpa.pop_front());
      void'(q_acc.pop_front());
      seen = 0;
    end
  end

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned base, size;
    base = 64'h10_0000_0000; size = 64'h6_0000_0000;
    cfg_base = AW'(base); cfg_size = AW'(size);
    repeat (4) @(negedge clk);
    chk(!out_valid && in_ready, "R10", "reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R10", "after reset", {out_valid, in_ready}, 2'b01);
    // R5: six-way ordering at 512 B
    for (int i = 0; i < 14; i++) send(base + 64'(i) * 512 + 64'(i * 7), 9, 1, "R5");
    // R11: twelve-way at 256 B
    for (int i = 0; i < 26; i++) send(base + 64'(i) * 256 + 64'(i), 10, 0, "R11");
    for (int i = 0; i < 9; i++) send(base + 64'(i) * 1024 + 5, 8, 2, "R4");
    // R1 R4 R6 power-of-two and three-based modes, random addresses, every granule
    for (int w = 0; w < 11; w++) begin
      if (w > 4 && w < 8) continue;
      for (int gr = 0; gr < 7; gr++)
        for (int j = 0; j < 4; j++)
          send(base + ({32'($urandom), 32'($urandom)} % size), w, gr, "R6");
    end
    // R3 window edges
    send(base, 9, 1, "R3");
    send(base + size - 1, 10, 3, "R3");
    send(base + size, 9, 1, "R7");
    send(base - 1, 2, 0, "R7");
    // R1 R2 bad codes
    send(base + 64'h1234, 5, 0, "R1");
    send(base + 64'h1234, 12, 2, "R1");
    send(base + 64'h1234, 3, 7, "R2");
    // R9 backpressure
    bp_mode = 1;
    for (int j = 0; j < 60; j++)
      send(base + ({32'($urandom), 32'($urandom)} % size), (j % 2) ? 9 : 3, j % 7, "R9");
    while (q_tgt.size() > 0) @(negedge clk);
    bp_mode = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule